// File: doc/BRIEF.md
# Mixed-Width Shift Execution Unit

This unit is the shift slice of a 64-bit integer pipeline. Each cycle it may take one 32-bit instruction word, two 64-bit source values and a valid strobe. It decodes the word. When the word is a shift, it computes the 64-bit result and presents it one clock later on a registered output, together with a result-valid flag and an illegal-encoding flag.

Three shift kinds are supported: logical left, logical right and arithmetic right. Each kind has a full-width form and a legacy half-width form, selected by one bit of the instruction word. Another bit chooses where the shift count comes from: the low bits of the second source value, or an immediate field in the instruction. The legacy forms behave unevenly across the 64-bit result. The legacy left shift moves the whole register but takes only a 5-bit count. The legacy right shifts act on the low word only and then zero-extend or sign-extend it to 64 bits. For this reason a legacy right shift by zero is the pipeline's way of widening a 32-bit value.

Top module: `shift_exec_unit`

## Requirements
- R1: A word is for this unit when `instr[31:30]` is 2'b10. It is a shift when, in addition, `instr[24:19]` is 6'b100101 (logical left), 6'b100110 (logical right) or 6'b100111 (arithmetic right).
- R2: `res_valid` is high in the cycle after a cycle in which `in_valid` is high and `instr[31:30]` is 2'b10, and low after any other cycle. Reset drives `res_valid`, `res_illegal` and `res_data` to zero.
- R3: When `instr[13]` is 1, the shift count is the immediate in the low instruction bits. When `instr[13]` is 0, the count is taken from `opnd_b`.
- R4: When `instr[12]` is 1 (full width), the count is 6 bits wide (`instr[5:0]` or `opnd_b[5:0]`). The shift is applied to all 64 bits of `opnd_a`, and the arithmetic form fills with `opnd_a[63]`.
- R5: The legacy logical left shift (`instr[12]`=0) shifts all 64 bits of `opnd_a` by a 5-bit count (`instr[4:0]` or `opnd_b[4:0]`).
- R6: The legacy logical right shift yields `opnd_a[31:0]` shifted right by the 5-bit count, with `res_data[63:32]` zero. A count of zero gives the zero-extended low word.
- R7: The legacy arithmetic right shift shifts `opnd_a[31:0]` arithmetically by the 5-bit count, and every bit of `res_data[63:32]` equals `res_data[31]`. A count of zero gives the sign-extended low word.
- R8: The following have no effect on the result: `opnd_b` bits above the count width (bit 6 and up for full width, bit 5 and up for legacy), `instr[5]` in legacy immediate mode, and the fields `instr[29:25]`, `instr[18:14]` and `instr[11:6]`.
- R9: When `instr[31:30]` is 2'b10 but `instr[24:19]` is not one of the three shift codes, `res_illegal` rises together with `res_valid` and `res_data` is zero. After a legal shift, `res_illegal` is low.
- R10: `res_data` and `res_illegal` keep their values through any cycle that accepts no input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction and operands are present |
| instr | input | 32 | Instruction word |
| opnd_a | input | 64 | Value to be shifted |
| opnd_b | input | 64 | Second source, supplies the count in register mode |
| res_valid | output | 1 | Registered result is valid |
| res_data | output | 64 | Registered shift result |
| res_illegal | output | 1 | Major opcode matched but operation is not a shift |

## Verification
Two things meet in the same cycle on every legacy right shift: the count selection and the upper-half fill. The sweep therefore drives every count from 0 to 63 in both count modes. It sets immediate bit 5 and the upper bits of `opnd_b` so that the ignored bits are exercised while the fill is formed. Operand patterns with bit 31 and bit 63 set in each combination separate zero extension, sign extension from bit 31 and sign extension from bit 63. Each result is compared against values computed arithmetically from the requirements. A second meeting point is the illegal flag and the result: every non-shift operation code is driven while the result register holds a non-zero value, and the output must fall to zero as the flag rises.

// File: rtl/sx_pkg.sv
package sx_pkg;

  localparam int INSTR_W = 32;
  localparam int IMM_W   = 6;

  localparam logic [1:0] MAJOR_ARITH = 2'b10;
  localparam logic [5:0] OPC_LEFT    = 6'b100101;
  localparam logic [5:0] OPC_RLOG    = 6'b100110;
  localparam logic [5:0] OPC_RARI    = 6'b100111;

  localparam int BIT_IMM  = 13;
  localparam int BIT_WIDE = 12;

  typedef enum logic [1:0] {
    SK_LEFT = 2'd0,
    SK_RLOG = 2'd1,
    SK_RARI = 2'd2,
    SK_NONE = 2'd3
  } shift_kind_e;

  typedef struct packed {
    logic             major;
    logic             legal;
    shift_kind_e      kind;
    logic             wide;
    logic             use_imm;
    logic [IMM_W-1:0] imm;
  } sx_dec_t;

endpackage

// File: rtl/sx_decode.sv
module sx_decode
  import sx_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  output sx_dec_t            dec
);

  logic [1:0] major_fld;
  logic [5:0] oper_fld;
  logic       unused_fields;

  assign major_fld     = instr[31:30];
  assign oper_fld      = instr[24:19];
  assign unused_fields = ^{instr[29:25], instr[18:14], instr[11:IMM_W]};

  always_comb begin
    dec         = '0;
    dec.major   = (major_fld == MAJOR_ARITH);
    dec.wide    = instr[BIT_WIDE];
    dec.use_imm = instr[BIT_IMM];
    dec.imm     = instr[IMM_W-1:0];
    dec.kind    = SK_NONE;
    dec.legal   = 1'b0;
    if (dec.major) begin
      unique case (oper_fld)
        OPC_LEFT: begin
          dec.kind  = SK_LEFT;
          dec.legal = 1'b1;
        end
        OPC_RLOG: begin
          dec.kind  = SK_RLOG;
          dec.legal = 1'b1;
        end
        OPC_RARI: begin
          dec.kind  = SK_RARI;
          dec.legal = 1'b1;
        end
        default: begin
          dec.kind  = SK_NONE;
          dec.legal = 1'b0;
        end
      endcase
    end
  end

endmodule

// File: rtl/sx_amount.sv
module sx_amount
  import sx_pkg::*;
#(
  parameter int DATA_W = 64,
  localparam int AMT_W = $clog2(DATA_W)
) (
  input  logic              wide,
  input  logic              use_imm,
  input  logic [IMM_W-1:0]  imm,
  input  logic [DATA_W-1:0] reg_val,
  output logic [AMT_W-1:0]  amt
);

  logic [AMT_W-1:0] raw;
  logic             unused_hi;

  assign unused_hi = ^reg_val[DATA_W-1:AMT_W];

  generate
    if (IMM_W > AMT_W) begin : g_trim
      logic unused_imm;
      assign unused_imm = ^imm[IMM_W-1:AMT_W];
    end
  endgenerate

  always_comb begin
    raw = use_imm ? imm[AMT_W-1:0] : reg_val[AMT_W-1:0];
    amt = raw;
    if (!wide) begin
      amt[AMT_W-1] = 1'b0;
    end
  end

endmodule

// File: rtl/sx_barrel.sv
module sx_barrel #(
  parameter int DATA_W = 64,
  localparam int AMT_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] din,
  input  logic [AMT_W-1:0]  amt,
  input  logic              to_left,
  input  logic              fill,
  output logic [DATA_W-1:0] dout
);

  logic [DATA_W-1:0] rev_in;
  logic [DATA_W-1:0] stage [0:AMT_W];
  logic [DATA_W-1:0] rev_out;

  genvar gb;
  generate
    for (gb = 0; gb < DATA_W; gb++) begin : g_rev
      assign rev_in[gb]  = din[DATA_W-1-gb];
      assign rev_out[gb] = stage[AMT_W][DATA_W-1-gb];
    end
  endgenerate

  assign stage[0] = to_left ? rev_in : din;

  genvar gs;
  generate
    for (gs = 0; gs < AMT_W; gs++) begin : g_stage
      localparam int SH = 1 << gs;
      logic [DATA_W-1:0] moved;
      assign moved = {{SH{fill}}, stage[gs][DATA_W-1:SH]};
      assign stage[gs+1] = amt[gs] ? moved : stage[gs];
    end
  endgenerate

  assign dout = to_left ? rev_out : stage[AMT_W];

endmodule

// File: rtl/shift_exec_unit.sv
module shift_exec_unit
  import sx_pkg::*;
#(
  parameter int DATA_W = 64,
  localparam int HALF_W = DATA_W / 2,
  localparam int AMT_W  = $clog2(DATA_W)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [INSTR_W-1:0] instr,
  input  logic [DATA_W-1:0]  opnd_a,
  input  logic [DATA_W-1:0]  opnd_b,
  output logic               res_valid,
  output logic [DATA_W-1:0]  res_data,
  output logic               res_illegal
);

  sx_dec_t           dec;
  logic [AMT_W-1:0]  amt;
  logic [DATA_W-1:0] prepped;
  logic              fill_bit;
  logic              go_left;
  logic [DATA_W-1:0] shifted;
  logic              accept;

  sx_decode u_decode (
    .instr (instr),
    .dec   (dec)
  );

  sx_amount #(.DATA_W(DATA_W)) u_amount (
    .wide    (dec.wide),
    .use_imm (dec.use_imm),
    .imm     (dec.imm),
    .reg_val (opnd_b),
    .amt     (amt)
  );

  // Legacy right shifts first widen the low word (zero or sign), then a
  // full-width right shift by at most HALF_W-1 leaves the upper half filled.
  always_comb begin
    go_left  = (dec.kind == SK_LEFT);
    prepped  = opnd_a;
    fill_bit = 1'b0;
    if (!go_left) begin
      if (dec.wide) begin
        fill_bit = (dec.kind == SK_RARI) & opnd_a[DATA_W-1];
        prepped  = opnd_a;
      end else begin
        fill_bit = (dec.kind == SK_RARI) & opnd_a[HALF_W-1];
        prepped  = {{HALF_W{fill_bit}}, opnd_a[HALF_W-1:0]};
      end
    end
  end

  sx_barrel #(.DATA_W(DATA_W)) u_barrel (
    .din     (prepped),
    .amt     (amt),
    .to_left (go_left),
    .fill    (fill_bit),
    .dout    (shifted)
  );

  assign accept = in_valid & dec.major;

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid   <= 1'b0;
      res_data    <= '0;
      res_illegal <= 1'b0;
    end else begin
      res_valid <= accept;
      if (accept) begin
        res_data    <= dec.legal ? shifted : '0;
        res_illegal <= ~dec.legal;
      end
    end
  end

endmodule

// File: rtl/sx_checker.sv
module sx_checker #(
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [31:0]       instr,
  input logic [DATA_W-1:0] opnd_a,
  input logic              res_valid,
  input logic [DATA_W-1:0] res_data,
  input logic              res_illegal
);

  localparam int HALF_W = DATA_W / 2;

  logic acc;
  logic leg_rlog;
  logic leg_rari;
  logic unused_a;

  assign unused_a = ^opnd_a;
  assign acc      = in_valid && (instr[31:30] == 2'b10);
  assign leg_rlog = acc && (instr[24:19] == 6'b100110) && !instr[12];
  assign leg_rari = acc && (instr[24:19] == 6'b100111) && !instr[12];

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
    acc |=> res_valid);

  a_r2_no_spurious_valid: assert property (@(posedge clk) disable iff (rst)
    !acc |=> !res_valid);

  a_r9_illegal_with_valid: assert property (@(posedge clk) disable iff (rst)
    res_illegal && $rose(res_illegal) |-> res_valid);

  a_r9_illegal_zero: assert property (@(posedge clk) disable iff (rst)
    res_valid && res_illegal |-> (res_data == '0));

  a_r6_upper_clear: assert property (@(posedge clk) disable iff (rst)
    leg_rlog |=> (res_data[DATA_W-1:HALF_W] == '0));

  a_r7_upper_sign: assert property (@(posedge clk) disable iff (rst)
    leg_rari |=> (res_data[DATA_W-1:HALF_W] == {HALF_W{res_data[HALF_W-1]}}));

  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    !acc |=> ($stable(res_data) && $stable(res_illegal)));

endmodule

bind shift_exec_unit sx_checker #(.DATA_W(DATA_W)) u_sx_checker (
  .clk         (clk),
  .rst         (rst),
  .in_valid    (in_valid),
  .instr       (instr),
  .opnd_a      (opnd_a),
  .res_valid   (res_valid),
  .res_data    (res_data),
  .res_illegal (res_illegal)
);

// File: tb/tb_shift_exec_unit.sv
module tb_shift_exec_unit;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [31:0] instr;
  logic [63:0] opnd_a;
  logic [63:0] opnd_b;
  logic        res_valid;
  logic [63:0] res_data;
  logic        res_illegal;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  shift_exec_unit dut (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .instr       (instr),
    .opnd_a      (opnd_a),
    .opnd_b      (opnd_b),
    .res_valid   (res_valid),
    .res_data    (res_data),
    .res_illegal (res_illegal)
  );

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [1:0] maj, input logic [5:0] op3,
                                     input logic imm, input logic wide, input logic [5:0] low);
    return {maj, 5'h15, op3, 5'h0A, imm, wide, 6'h2D, low};
  endfunction

  function automatic logic [63:0] model(input int kind, input logic wide,
                                        input logic [5:0] cnt, input logic [63:0] a);
    logic [63:0] r;
    logic [31:0] lo;
    int n;
    n = wide ? int'(cnt) : int'(cnt[4:0]);
    if (kind == 0) begin
      r = a << n;
    end else if (wide) begin
      if (kind == 1) r = a >> n;
      else           r = 64'($signed(a) >>> n);
    end else begin
      if (kind == 1) begin
        lo = a[31:0] >> n;
        r  = {32'h0, lo};
      end else begin
        lo = 32'($signed(a[31:0]) >>> n);
        r  = {{32{lo[31]}}, lo};
      end
    end
    return r;
  endfunction

  task automatic issue(input logic [31:0] w, input logic [63:0] a, input logic [63:0] b);
    @(negedge clk);
    in_valid = 1'b1;
    instr    = w;
    opnd_a   = a;
    opnd_b   = b;
    @(negedge clk);
    in_valid = 1'b0;
    instr    = 32'h0;
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      n_fail++;
      $display("FAIL R2 watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [63:0] pats [4];
    logic [5:0]  codes [3];
    logic [63:0] held;
    pats[0]  = 64'hF0E1_D2C3_B4A5_9687;
    pats[1]  = 64'h0123_4567_89AB_CDEF;
    pats[2]  = 64'hFFFF_FFFF_7FFF_FFFE;
    pats[3]  = 64'h0000_0000_0000_0001;
    codes[0] = 6'b100101;
    codes[1] = 6'b100110;
    codes[2] = 6'b100111;

    rst = 1'b1; in_valid = 1'b0; instr = '0; opnd_a = '0; opnd_b = '0;
    repeat (3) @(negedge clk);
    check("R2 reset valid", {63'h0, res_valid}, 64'h0);
    check("R2 reset data", res_data, 64'h0);
    check("R2 reset illegal", {63'h0, res_illegal}, 64'h0);
    rst = 1'b0;

    // Sweep: kind x width x count source x count x operand pattern (R1,R3,R4..R8)
    for (int k = 0; k < 3; k++) begin
      for (int w = 0; w < 2; w++) begin
        for (int im = 0; im < 2; im++) begin
          for (int c = 0; c < 64; c++) begin
            for (int p = 0; p < 4; p++) begin
              logic [63:0] b;
              logic [63:0] exp;
              string tag;
              b   = {58'h2AA_AAAA_5555_5555 ^ 58'(p * 7919), 6'(c)};
              exp = model(k, w[0], 6'(c), pats[p]);
              if (w == 1)      tag = "R4";
              else if (k == 0) tag = "R5";
              else if (k == 1) tag = "R6";
              else             tag = "R7";
              tag = $sformatf("%s R1 R3 R8 k=%0d imm=%0d cnt=%0d p=%0d", tag, k, im, c, p);
              if (im == 1) issue(mk(2'b10, codes[k], 1'b1, w[0], 6'(c)), pats[p], ~b);
              else         issue(mk(2'b10, codes[k], 1'b0, w[0], 6'h3F), pats[p], b);
              check({tag, " valid"}, {63'h0, res_valid}, 64'h1);
              check({tag, " illegal"}, {63'h0, res_illegal}, 64'h0);
              check(tag, res_data, exp);
            end
          end
        end
      end
    end

    // Illegal operation codes under the arithmetic major opcode (R9)
    for (int o = 0; o < 64; o++) begin
      if (o < 37 || o > 39) begin
        issue(mk(2'b10, codes[0], 1'b1, 1'b1, 6'd4), 64'hFFFF_0000_1234_5678, 64'h0);
        issue(mk(2'b10, 6'(o), 1'b1, 1'b1, 6'd4), 64'hFFFF_0000_1234_5678, 64'h0);
        check($sformatf("R9 valid op3=%0d", o), {63'h0, res_valid}, 64'h1);
        check($sformatf("R9 flag op3=%0d", o), {63'h0, res_illegal}, 64'h1);
        check($sformatf("R9 data op3=%0d", o), res_data, 64'h0);
      end
    end

    // Legal shift after illegal clears the flag (R9)
    issue(mk(2'b10, codes[2], 1'b1, 1'b0, 6'd0), 64'h0000_0000_8000_0000, 64'h0);
    check("R9 flag cleared", {63'h0, res_illegal}, 64'h0);
    check("R7 zero count sign-extend", res_data, 64'hFFFF_FFFF_8000_0000);
    held = res_data;

    // Other major opcodes are not accepted and leave outputs held (R2, R10)
    for (int m = 0; m < 4; m++) begin
      if (m != 2) begin
        issue(mk(2'(m), codes[0], 1'b1, 1'b1, 6'd1), 64'h1, 64'h0);
        check($sformatf("R2 no valid major=%0d", m), {63'h0, res_valid}, 64'h0);
        check($sformatf("R10 data held major=%0d", m), res_data, held);
        check($sformatf("R10 flag held major=%0d", m), {63'h0, res_illegal}, 64'h0);
      end
    end

    // Idle cycle with a shift word present but no strobe (R2, R10)
    @(negedge clk);
    instr  = mk(2'b10, codes[0], 1'b1, 1'b1, 6'd3);
    opnd_a = 64'h1;
    @(negedge clk);
    check("R2 no strobe no valid", {63'h0, res_valid}, 64'h0);
    check("R10 no strobe data held", res_data, held);

    // Zero-count legacy logical right shift widens with zeros (R6)
    issue(mk(2'b10, codes[1], 1'b0, 1'b0, 6'h00), 64'hDEAD_BEEF_8765_4321, 64'hFFFF_FFFF_FFFF_FFE0);
    check("R6 zero count zero-extend", res_data, 64'h0000_0000_8765_4321);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule